// File: doc/BRIEF.md
# I2C Memory Read Engine

This block is an I2C target that holds a 2048-byte memory and answers reads from a bus master. It watches SCL and SDA through a synchroniser clocked by the system clock. It treats SDA as an open-drain line: `sda_in` is the resolved bus level, and `sda_pull` pulls the line low when high. START, repeated START and STOP are all recognised. A master loads the internal address counter with a write transaction that carries a device address and two word-address bytes but no data. After a repeated START and the device address with the read bit set, the block streams bytes from that address.

The address counter steps by one after every byte sent. It wraps from the last location to the first inside one burst. A read that comes without an address write carries on from the current counter value. A side-band load port fills the memory, one byte per clock. While `access_block` is high, the engine stays idle and acknowledges nothing.

The control state machine has these states:
- `ST_IDLE` waits for a START.
- `ST_DEV` receives the device byte.
- `ST_DEV_ACK` acknowledges it.
- `ST_AHI` / `ST_AHI_ACK` take the upper address byte.
- `ST_ALO` / `ST_ALO_ACK` take the lower address byte.
- `ST_TX` shifts a data byte out.
- `ST_TX_ACK` leaves the line to the master for its ACK/NACK.

Transitions:
- START moves any state to `ST_DEV`.
- STOP or `access_block` moves any state to `ST_IDLE`.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_IDLE` otherwise.
- `ST_DEV_ACK` goes to `ST_TX` when the read bit is 1 and to `ST_AHI` when it is 0.
- `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_IDLE`.
- `ST_TX` → `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX` on a master ACK and to `ST_IDLE` on a NACK.

Top module: `i2c_mem_reader`

## Requirements
- R1: After reset `sda_pull` is 0 and the engine ignores the bus until a START.
- R2: The engine acknowledges the following, by pulling SDA low during the ninth SCL pulse of each byte:
  - a device byte whose upper seven bits equal `DEV_ADDR` with bit 0 (R/W) at 0;
  - the two word-address bytes that follow it.
- R3: The word address is 11 bits. The low 3 bits of the first address byte form bits 10..8, and the second byte forms bits 7..0. The upper 5 bits of the first address byte are ignored.
- R4: After a repeated START and a matching device byte with R/W at 1, the engine acknowledges. It then sends the byte at the latched address, MSB first.
- R5: A master ACK after a data byte makes the engine send the byte at the next address. A master NACK followed by STOP leaves `sda_pull` at 0.
- R6: In one burst the address counter wraps from 2047 to 0.
- R7: A read with no preceding address write starts at the address after the last byte sent.
- R8: A device byte that does not match gets no ACK, whether R/W is 0 or 1. The engine then ignores the bus until the next START, and the address counter keeps its value.
- R9: While `access_block` is 1, nothing is acknowledged. `sda_pull` falls to 0 within two clocks of `access_block` rising, even in the middle of a byte.
- R10: `sda_pull` rises only while SCL is low. It is 0 during every master ACK/NACK bit.
- R11: When `load_we` is 1 at a clock edge, `load_data` is written to memory location `load_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Resolved bus data level |
| sda_pull | output | 1 | When 1, pull SDA low |
| access_block | input | 1 | While 1, bus access is refused |
| load_we | input | 1 | Side-band memory write strobe |
| load_addr | input | 11 | Side-band write address |
| load_data | input | 8 | Side-band write data |

## Verification
Two functions can fall in the same system clock:
- Holding access closed can coincide with transmitting a data bit.
- An address increment with wrap can coincide with the reload that follows a master ACK.

The bench provokes the first case with a specific address choice:
- It picks an address whose next byte has a 0 MSB, so the engine is pulling SDA low for bit 7 after the master ACK.
- It raises `access_block` at that moment.
- It then checks that the pull is present before the raise and gone two clocks after it.

For the second case, a burst crossing 2047 → 0 is scored byte by byte against a model of the memory contents. An in-design property also checks that every completed byte advances the counter by exactly one, modulo 2048.

// File: rtl/i2crd_pkg.sv
package i2crd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_TX,
        ST_TX_ACK
    } rd_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2crd_busmon.sv
module i2crd_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_p;
    logic                   sda_p;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_in;
                        sda_pipe[g] <= sda_in;
                    end
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_pipe[g] <= 1'b1;
                        sda_pipe[g] <= 1'b1;
                    end else begin
                        scl_pipe[g] <= scl_pipe[g-1];
                        sda_pipe[g] <= sda_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  =  scl_s && !scl_p;
    assign scl_fall  = !scl_s &&  scl_p;
    assign start_det =  scl_s &&  scl_p &&  sda_p && !sda_s;
    assign stop_det  =  scl_s &&  scl_p && !sda_p &&  sda_s;

endmodule

// File: rtl/i2crd_rxshift.sv
module i2crd_rxshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         consume,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);

    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            full_o <= 1'b0;
            data_o <= '0;
        end else if (clear) begin
            cnt    <= '0;
            full_o <= 1'b0;
        end else if (sample) begin
            data_o <= {data_o[W-2:0], bit_i};
            if (cnt == CW'(W - 1)) begin
                cnt    <= '0;
                full_o <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (consume) begin
            full_o <= 1'b0;
        end
    end

    // R2: a byte is only reported complete after a sampled bit
    p_full_from_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(sample));

endmodule

// File: rtl/i2crd_mem.sv
module i2crd_mem #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/i2crd_ctrl.sv
module i2crd_ctrl
    import i2crd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         AW       = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [7:0]    rx_byte,
    input  logic          rx_full,
    input  logic [7:0]    mem_rdata,
    output logic          rx_clear,
    output logic          rx_sample,
    output logic          rx_consume,
    output logic [AW-1:0] rd_addr,
    output logic          sda_pull
);

    localparam int HI_W = AW - BYTE_W;

    rd_state_e       state, state_d;
    logic            pull_d;
    logic            tx_load, tx_shift, addr_inc, ahi_set, addr_set, rw_set, mack_set;
    logic [7:0]      tx_sh;
    logic [2:0]      tx_cnt;
    logic [AW-1:0]   addr_q;
    logic [HI_W-1:0] ahi_q;
    logic            rw_q;
    logic            mack_q;
    logic            rx_state;
    logic            dev_hit;

    assign rx_state   = (state == ST_DEV) || (state == ST_AHI) || (state == ST_ALO);
    assign rx_clear   = start_det || stop_det || hold_i || !rx_state;
    assign rx_sample  = rx_state && scl_rise;
    assign rx_consume = rx_state && scl_fall && rx_full;
    assign dev_hit    = (rx_byte[7:1] == DEV_ADDR);
    assign rd_addr    = addr_q;

    // next state and control strobes
    always_comb begin
        state_d  = state;
        pull_d   = sda_pull;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        addr_inc = 1'b0;
        ahi_set  = 1'b0;
        addr_set = 1'b0;
        rw_set   = 1'b0;
        mack_set = 1'b0;
        if (hold_i) begin
            state_d = ST_IDLE;
            pull_d  = 1'b0;
        end else if (start_det) begin
            state_d = ST_DEV;
            pull_d  = 1'b0;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            pull_d  = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_DEV: begin
                    if (rx_consume) begin
                        if (dev_hit) begin
                            state_d = ST_DEV_ACK;
                            pull_d  = 1'b1;
                            rw_set  = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            state_d = ST_TX;
                            tx_load = 1'b1;
                            pull_d  = ~mem_rdata[7];
                        end else begin
                            state_d = ST_AHI;
                            pull_d  = 1'b0;
                        end
                    end
                end
                ST_AHI: begin
                    if (rx_consume) begin
                        state_d = ST_AHI_ACK;
                        pull_d  = 1'b1;
                        ahi_set = 1'b1;
                    end
                end
                ST_AHI_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_ALO;
                        pull_d  = 1'b0;
                    end
                end
                ST_ALO: begin
                    if (rx_consume) begin
                        state_d  = ST_ALO_ACK;
                        pull_d   = 1'b1;
                        addr_set = 1'b1;
                    end
                end
                ST_ALO_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_IDLE;
                        pull_d  = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (tx_cnt == 3'd7) begin
                            state_d  = ST_TX_ACK;
                            pull_d   = 1'b0;
                            addr_inc = 1'b1;
                        end else begin
                            tx_shift = 1'b1;
                            pull_d   = ~tx_sh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_set = 1'b1;
                    end
                    if (scl_fall) begin
                        if (mack_q) begin
                            state_d = ST_TX;
                            tx_load = 1'b1;
                            pull_d  = ~mem_rdata[7];
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    pull_d  = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            tx_sh    <= '0;
            tx_cnt   <= '0;
            addr_q   <= '0;
            ahi_q    <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
        end else begin
            sda_pull <= pull_d;
            if (tx_load) begin
                tx_sh  <= mem_rdata;
                tx_cnt <= '0;
            end else if (tx_shift) begin
                tx_sh  <= {tx_sh[6:0], 1'b0};
                tx_cnt <= tx_cnt + 1'b1;
            end
            if (addr_set) begin
                addr_q <= {ahi_q, rx_byte};
            end else if (addr_inc) begin
                addr_q <= addr_q + 1'b1;
            end
            if (ahi_set) begin
                ahi_q <= rx_byte[HI_W-1:0];
            end
            if (rw_set) begin
                rw_q <= rx_byte[0];
            end
            if (mack_set) begin
                mack_q <= !sda_s;
            end
        end
    end

    // R9: blocked access releases the line on the next clock
    p_hold_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> !sda_pull);

    // R10: the pull is only applied while SCL is low
    p_pull_rise_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R10: master ACK/NACK slot is left free
    p_master_slot_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK) |-> !sda_pull);

    // R6: each completed byte advances the counter by one, wrapping at the top
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && state_d == ST_TX_ACK && !hold_i && !start_det && !stop_det)
        |=> addr_q == AW'($past(addr_q) + 1'b1));

    // R8: never drive while receiving a byte from the master
    p_rx_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state |-> !sda_pull);

    // R5: STOP frees the line
    p_stop_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

endmodule

// File: rtl/i2c_mem_reader.sv
module i2c_mem_reader #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         MEM_DEPTH   = 2048,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_in,
    input  logic                         sda_in,
    output logic                         sda_pull,
    input  logic                         access_block,
    input  logic                         load_we,
    input  logic [$clog2(MEM_DEPTH)-1:0] load_addr,
    input  logic [7:0]                   load_data
);

    localparam int AW = $clog2(MEM_DEPTH);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          rx_clear, rx_sample, rx_consume, rx_full;
    logic [7:0]    rx_byte;
    logic [7:0]    mem_rdata;
    logic [AW-1:0] rd_addr;

    i2crd_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2crd_rxshift #(.W(8)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rx_clear),
        .sample  (rx_sample),
        .consume (rx_consume),
        .bit_i   (sda_s),
        .data_o  (rx_byte),
        .full_o  (rx_full)
    );

    i2crd_mem #(.DEPTH(MEM_DEPTH), .DW(8), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (load_we),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (rd_addr),
        .rd_data (mem_rdata)
    );

    i2crd_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (access_block),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .rx_byte    (rx_byte),
        .rx_full    (rx_full),
        .mem_rdata  (mem_rdata),
        .rx_clear   (rx_clear),
        .rx_sample  (rx_sample),
        .rx_consume (rx_consume),
        .rd_addr    (rd_addr),
        .sda_pull   (sda_pull)
    );

    // R1: nothing driven in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !sda_pull);

endmodule

// File: tb/i2c_mem_reader_tb.sv
module i2c_mem_reader_tb;

    localparam int         Q   = 10;
    localparam logic [6:0] DEV = 7'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        hold = 1'b0;
    logic        ld_we = 1'b0;
    logic [10:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        sda_pull;
    logic        sda_bus;

    assign sda_bus = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    i2c_mem_reader u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .sda_pull     (sda_pull),
        .access_block (hold),
        .load_we      (ld_we),
        .load_addr    (ld_addr),
        .load_data    (ld_data)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    int          viol  = 0;
    bit          done  = 1'b0;
    logic [7:0]  model [2048];
    logic [8:0]  exp_q [$];
    string       tag_q [$];
    logic [8:0]  obs_q [$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        if (obs_q.size() > 0) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL unexpected item actual=%0h expected=none", obs_q.pop_front());
            end else begin
                check(tag_q.pop_front(), 32'(obs_q.pop_front()), 32'(exp_q.pop_front()));
            end
        end
    end

    // R10: pull must not start while SCL is high
    logic pull_prev = 1'b0;
    always @(negedge clk) begin
        if (sda_pull && !pull_prev && scl) viol++;
        pull_prev <= sda_pull;
    end

    function automatic logic [7:0] pattern(input int a);
        logic [10:0] x;
        x = 11'(a);
        return (x[7:0] ^ {x[10:8], 5'b0}) + 8'h5A;
    endfunction

    task automatic qwait(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic expect_item(input string tag, input logic [8:0] v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        scl = 1'b1;   qwait();
        m_sda = 1'b0; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        scl = 1'b1;   qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag, input bit exp_ack);
        bit ack;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qwait();
            scl = 1'b1;   qwait(2);
            scl = 1'b0;   qwait();
        end
        m_sda = 1'b1; qwait();
        scl = 1'b1;   qwait();
        ack = !sda_bus;
        qwait();
        scl = 1'b0;   qwait();
        expect_item(tag, {1'b1, 7'b0, exp_ack});
        obs_q.push_back({1'b1, 7'b0, ack});
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl = 1'b1; qwait();
            b[i] = sda_bus;
            qwait();
            scl = 1'b0; qwait();
        end
        m_sda = !mack; qwait();
        scl = 1'b1;    qwait();
        check("R10 master slot free", 32'(sda_pull), 32'd0);
        qwait();
        scl = 1'b0;    qwait();
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input string tag, input logic [10:0] a, input logic [4:0] junk);
        bus_start();
        send_byte({DEV, 1'b0}, "R2 dev write ack", 1'b1);
        send_byte({junk, a[10:8]}, tag, 1'b1);
        send_byte(a[7:0], "R2 low addr ack", 1'b1);
    endtask

    task automatic read_burst(input string tag, input int n, input int a0);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            expect_item(tag, {1'b0, model[(a0 + k) % 2048]});
            recv_byte(k < n - 1, b);
            obs_q.push_back({1'b0, b});
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        int sel;
        logic [7:0] dummy;
        repeat (5) @(negedge clk);
        check("R1 reset pull", 32'(sda_pull), 32'd0);
        rst_n = 1'b1;

        // R11: preload through the side-band port
        for (int a = 0; a < 2048; a++) begin
            ld_we = 1'b1; ld_addr = 11'(a); ld_data = pattern(a);
            model[a] = pattern(a);
            @(negedge clk);
        end
        ld_we = 1'b0;
        qwait();

        // R3/R4/R5: random read, junk in upper address bits, 3-byte burst
        set_addr("R3 high addr ack", 11'h123, 5'b11111);
        bus_start();
        send_byte({DEV, 1'b1}, "R4 dev read ack", 1'b1);
        read_burst("R5 sequential", 3, 'h123);
        bus_stop();
        qwait();
        check("R5 released after stop", 32'(sda_pull), 32'd0);

        // R4: single byte random read
        set_addr("R3 high addr ack", 11'h400, 5'b00000);
        bus_start();
        send_byte({DEV, 1'b1}, "R4 dev read ack", 1'b1);
        read_burst("R4 first byte", 1, 'h400);
        bus_stop();

        // R7: current-address read continues from 0x401
        bus_start();
        send_byte({DEV, 1'b1}, "R7 dev read ack", 1'b1);
        read_burst("R7 current address", 2, 'h401);
        bus_stop();

        // R6: wrap across the top of memory
        set_addr("R3 high addr ack", 11'h7FE, 5'b10101);
        bus_start();
        send_byte({DEV, 1'b1}, "R6 dev read ack", 1'b1);
        read_burst("R6 wrap", 4, 'h7FE);
        bus_stop();

        // R8: foreign address, write and read, then counter still at 0x002
        bus_start();
        send_byte({7'h51, 1'b0}, "R8 foreign write nack", 1'b0);
        send_byte(8'h00, "R8 ignored byte nack", 1'b0);
        bus_stop();
        bus_start();
        send_byte({7'h51, 1'b1}, "R8 foreign read nack", 1'b0);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, "R8 dev read ack", 1'b1);
        read_burst("R8 counter kept", 1, 'h002);
        bus_stop();

        // R9: blocked transaction gets no ACK
        hold = 1'b1; qwait();
        bus_start();
        send_byte({DEV, 1'b0}, "R9 blocked nack", 1'b0);
        bus_stop();
        hold = 1'b0; qwait();

        // R9: block raised while a 0 bit is being driven
        sel = 0;
        for (int a = 16; a < 2047; a++) begin
            if (sel == 0 && model[a + 1][7] == 1'b0) sel = a;
        end
        set_addr("R3 high addr ack", 11'(sel), 5'b00000);
        bus_start();
        send_byte({DEV, 1'b1}, "R9 dev read ack", 1'b1);
        expect_item("R9 byte before block", {1'b0, model[sel]});
        recv_byte(1'b1, dummy);
        obs_q.push_back({1'b0, dummy});
        check("R9 driving before block", 32'(sda_pull), 32'd1);
        hold = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 released by block", 32'(sda_pull), 32'd0);
        bus_stop();
        hold = 1'b0; qwait();

        // R11: overwrite one location and read it back
        ld_we = 1'b1; ld_addr = 11'h055; ld_data = 8'hC3;
        @(negedge clk);
        ld_we = 1'b0;
        model['h055] = 8'hC3;
        set_addr("R3 high addr ack", 11'h055, 5'b01000);
        bus_start();
        send_byte({DEV, 1'b1}, "R11 dev read ack", 1'b1);
        read_burst("R11 loaded byte", 1, 'h055);
        bus_stop();

        repeat (20) @(negedge clk);
        check("R10 no pull under high SCL", 32'(viol), 32'd0);
        check("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        finish_run();
    end

endmodule